// File: doc/BRIEF.md
# In-Order Retirement Ring

This block tracks instructions that may finish out of order and retires them in the order they were issued. It keeps a ring of entries with a head pointer and a tail pointer. The front end claims a slot at the tail for each new instruction in program order. The slot records whether the instruction writes an architectural register and which one. It also records whether the instruction is a store and, if so, its target address. The slot index is handed back so that an execution unit can later report on it.

An execution unit reports completion by slot index, with a result value and a fault flag. The entry at the head leaves the ring only once it has been reported finished. If it is clean, it either writes the architectural register file or releases its store to memory. The result value doubles as store data. If it carries a fault, the whole ring is discarded in one cycle and the faulting slot index is reported. No store reaches memory before its own retirement.

Top module: `retire_ring`

## Requirements
- R1: After reset the ring is empty: `empty` is 1, `alloc_ready` is 1, `alloc_idx` is 0, and `rf_we`, `mem_we` and `flush` are all 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` both high) takes the slot shown on `alloc_idx`. Successive accepted allocations take consecutive slots, modulo the depth.
- R3: Once depth entries are held, `alloc_ready` is 0. An `alloc_valid` in that state is ignored, and `alloc_idx` does not move.
- R4: A completion names a slot by `cmp_idx`. A completion aimed at a slot that holds no entry has no effect: an instruction later allocated into that slot does not retire until it is completed itself.
- R5: The head entry retires only once it is completed. Younger entries that are already completed wait behind an unfinished head.
- R6: A clean, completed head entry marked as a register writer raises `rf_we` for one cycle, with its destination on `rf_waddr` and its result on `rf_wdata`.
- R7: A clean, completed head store raises `mem_we` with its recorded address and its result as data. `mem_we` is never raised for a store before that point.
- R8: A completed head entry with its fault flag set raises `flush` with its slot index on `flush_idx`. In that cycle `rf_we` and `mem_we` stay low and `alloc_ready` is 0, and the next cycle the ring is empty.
- R9: A completed head entry that neither writes a register nor stores retires with no write and frees its slot.
- R10: At most one entry retires per cycle. A retirement and an allocation may happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_valid | input | 1 | Request to allocate a new entry at the tail |
| alloc_dest | input | AREG_W | Architectural destination register |
| alloc_wr_reg | input | 1 | Entry writes a register on retirement |
| alloc_store | input | 1 | Entry is a store |
| alloc_addr | input | ADDR_W | Store target address |
| alloc_ready | output | 1 | Allocation accepted this cycle if requested |
| alloc_idx | output | IDX_W | Slot that the next allocation takes |
| cmp_valid | input | 1 | Completion report |
| cmp_idx | input | IDX_W | Slot being completed |
| cmp_value | input | DATA_W | Result value or store data |
| cmp_fault | input | 1 | Instruction raised an exception |
| rf_we | output | 1 | Architectural register write |
| rf_waddr | output | AREG_W | Register being written |
| rf_wdata | output | DATA_W | Value written |
| mem_we | output | 1 | Store released to memory |
| mem_addr | output | ADDR_W | Store address |
| mem_wdata | output | DATA_W | Store data |
| flush | output | 1 | Fault at head, ring discarded |
| flush_idx | output | IDX_W | Slot of the faulting entry |
| empty | output | 1 | No entries held |

## Verification
The bench attacks the ring at its limits. It fills it to depth, where a design with a wrong wrap bit would mistake full for empty and overwrite the oldest entry. It completes young slots before old ones, where an out-of-order design would write registers early. It aims completions at free slots, which a careless design would leave marked as finished, so that a fresh instruction retires with a stale value. It also raises faults at the head with completed younger work behind it: a wrong flush would let one of those younger stores or register writes escape, or would leave the tail where it was.

// File: rtl/retire_ring_pkg.sv
package retire_ring_pkg;

  // What the head slot does this cycle
  typedef enum logic [2:0] {
    RET_IDLE,    // ring empty
    RET_WAIT,    // head still executing
    RET_REG,     // commit to register file
    RET_STORE,   // release store to memory
    RET_SILENT,  // commit with no visible write
    RET_FAULT    // exception: discard everything
  } ret_kind_e;

endpackage

// File: rtl/rr_ptr.sv
// Ring pointer carrying one extra wrap bit above the slot index.
module rr_ptr #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  output logic [PW-1:0] ptr
);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = load | adv;
    if (load) begin
      ptr_d = load_val;
    end else if (adv) begin
      ptr_d = ptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/rr_slots.sv
// Entry storage: per-slot control state with reset, payload without.
module rr_slots #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [IDX_W:0]    count,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [AREG_W-1:0] alloc_dest,
  input  logic              alloc_wr_reg,
  input  logic              alloc_store,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              cmp_we,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_fault,
  output logic [AREG_W-1:0] hd_dest,
  output logic              hd_wr_reg,
  output logic              hd_store,
  output logic [ADDR_W-1:0] hd_addr,
  output logic [DATA_W-1:0] hd_value,
  output logic              hd_fault,
  output logic              hd_done
);

  logic [DEPTH-1:0]  done_v;
  logic [DEPTH-1:0]  fault_v;
  logic [DEPTH-1:0]  wreg_v;
  logic [DEPTH-1:0]  st_v;
  logic [AREG_W-1:0] dest_a [DEPTH];
  logic [ADDR_W-1:0] addr_a [DEPTH];
  logic [DATA_W-1:0] val_a  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [IDX_W-1:0]  rel;
    logic              occ;
    logic              hit_a;
    logic              hit_c;
    logic              done_q, done_d;
    logic              flt_q, flt_d;
    logic              ctl_en;
    logic [AREG_W-1:0] dest_q;
    logic              wreg_q;
    logic              st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] val_q;

    // slot is live when its distance from head is below the count
    assign rel   = IDX_W'(g) - head_idx;
    assign occ   = {1'b0, rel} < count;
    assign hit_a = alloc_we && (alloc_idx == IDX_W'(g));
    assign hit_c = cmp_we && (cmp_idx == IDX_W'(g)) && occ;

    always_comb begin
      done_d = done_q;
      flt_d  = flt_q;
      ctl_en = hit_a | hit_c;
      if (hit_a) begin
        done_d = 1'b0;
        flt_d  = 1'b0;
      end else if (hit_c) begin
        done_d = 1'b1;
        flt_d  = cmp_fault;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q <= 1'b0;
        flt_q  <= 1'b0;
      end else if (ctl_en) begin
        done_q <= done_d;
        flt_q  <= flt_d;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_a) begin
        dest_q <= alloc_dest;
        wreg_q <= alloc_wr_reg;
        st_q   <= alloc_store;
        addr_q <= alloc_addr;
      end
      if (hit_c) begin
        val_q <= cmp_value;
      end
    end

    assign done_v[g]  = done_q;
    assign fault_v[g] = flt_q;
    assign wreg_v[g]  = wreg_q;
    assign st_v[g]    = st_q;
    assign dest_a[g]  = dest_q;
    assign addr_a[g]  = addr_q;
    assign val_a[g]   = val_q;
  end

  assign hd_done   = done_v[head_idx];
  assign hd_fault  = fault_v[head_idx];
  assign hd_wr_reg = wreg_v[head_idx];
  assign hd_store  = st_v[head_idx];
  assign hd_dest   = dest_a[head_idx];
  assign hd_addr   = addr_a[head_idx];
  assign hd_value  = val_a[head_idx];

endmodule

// File: rtl/rr_retire.sv
// Decides what the head slot does in the current cycle.
module rr_retire
  import retire_ring_pkg::*;
(
  input  logic      is_empty,
  input  logic      hd_done,
  input  logic      hd_fault,
  input  logic      hd_store,
  input  logic      hd_wr_reg,
  output ret_kind_e kind
);

  always_comb begin
    if (is_empty) begin
      kind = RET_IDLE;
    end else if (!hd_done) begin
      kind = RET_WAIT;
    end else if (hd_fault) begin
      kind = RET_FAULT;
    end else if (hd_store) begin
      kind = RET_STORE;
    end else if (hd_wr_reg) begin
      kind = RET_REG;
    end else begin
      kind = RET_SILENT;
    end
  end

endmodule

// File: rtl/retire_ring.sv
module retire_ring
  import retire_ring_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [AREG_W-1:0] alloc_dest,
  input  logic              alloc_wr_reg,
  input  logic              alloc_store,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_fault,
  output logic              rf_we,
  output logic [AREG_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              flush,
  output logic [IDX_W-1:0]  flush_idx,
  output logic              empty
);

  localparam int PW = IDX_W + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  logic [PW-1:0]     head_ptr;
  logic [PW-1:0]     tail_ptr;
  logic [PW-1:0]     count;
  logic              full;
  logic              alloc_fire;
  logic              retire_adv;
  logic              fault;
  logic              cmp_we;
  ret_kind_e         kind;
  logic [AREG_W-1:0] hd_dest;
  logic              hd_wr_reg;
  logic              hd_store;
  logic [ADDR_W-1:0] hd_addr;
  logic [DATA_W-1:0] hd_value;
  logic              hd_fault;
  logic              hd_done;

  assign count       = tail_ptr - head_ptr;
  assign full        = (count == FULL_CNT);
  assign empty       = (count == '0);
  assign fault       = (kind == RET_FAULT);
  assign alloc_ready = !full && !fault;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_ptr[IDX_W-1:0];
  assign cmp_we      = cmp_valid && !fault;
  assign retire_adv  = (kind == RET_REG) || (kind == RET_STORE) ||
                       (kind == RET_SILENT);

  rr_ptr #(.PW(PW)) u_head (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .adv      (retire_adv),
    .load     (1'b0),
    .load_val (head_ptr),
    .ptr      (head_ptr)
  );

  // on a fault the tail snaps back onto the head, emptying the ring
  rr_ptr #(.PW(PW)) u_tail (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .adv      (alloc_fire),
    .load     (fault),
    .load_val (head_ptr),
    .ptr      (tail_ptr)
  );

  rr_slots #(
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .AREG_W (AREG_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_slots (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .head_idx     (head_ptr[IDX_W-1:0]),
    .count        (count),
    .alloc_we     (alloc_fire),
    .alloc_idx    (tail_ptr[IDX_W-1:0]),
    .alloc_dest   (alloc_dest),
    .alloc_wr_reg (alloc_wr_reg),
    .alloc_store  (alloc_store),
    .alloc_addr   (alloc_addr),
    .cmp_we       (cmp_we),
    .cmp_idx      (cmp_idx),
    .cmp_value    (cmp_value),
    .cmp_fault    (cmp_fault),
    .hd_dest      (hd_dest),
    .hd_wr_reg    (hd_wr_reg),
    .hd_store     (hd_store),
    .hd_addr      (hd_addr),
    .hd_value     (hd_value),
    .hd_fault     (hd_fault),
    .hd_done      (hd_done)
  );

  rr_retire u_retire (
    .is_empty  (empty),
    .hd_done   (hd_done),
    .hd_fault  (hd_fault),
    .hd_store  (hd_store),
    .hd_wr_reg (hd_wr_reg),
    .kind      (kind)
  );

  assign rf_we     = (kind == RET_REG);
  assign rf_waddr  = hd_dest;
  assign rf_wdata  = hd_value;
  assign mem_we    = (kind == RET_STORE);
  assign mem_addr  = hd_addr;
  assign mem_wdata = hd_value;
  assign flush     = fault;
  assign flush_idx = head_ptr[IDX_W-1:0];

endmodule

// File: rtl/retire_ring_chk.sv
module retire_ring_chk #(
  parameter int PW    = 4,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] count,
  input logic [PW-1:0] head_ptr,
  input logic          alloc_ready,
  input logic          rf_we,
  input logic          mem_we,
  input logic          flush,
  input logic          empty
);

  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));

  // R3
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == PW'(DEPTH)) |-> !alloc_ready);

  // R10
  one_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rf_we, mem_we, flush}) <= 1);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  // R10
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || mem_we) |=> (head_ptr == $past(head_ptr) + PW'(1)));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !(rf_we || mem_we || flush));

endmodule

bind retire_ring retire_ring_chk #(.PW(PW), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .count       (count),
  .head_ptr    (head_ptr),
  .alloc_ready (alloc_ready),
  .rf_we       (rf_we),
  .mem_we      (mem_we),
  .flush       (flush),
  .empty       (empty)
);

// File: tb/sim_retire_ring.sv
module sim_retire_ring;
  localparam int DEPTH  = 8;
  localparam int IDX_W  = 3;
  localparam int AREG_W = 5;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_valid;
  logic [AREG_W-1:0] alloc_dest;
  logic              alloc_wr_reg;
  logic              alloc_store;
  logic [ADDR_W-1:0] alloc_addr;
  logic              alloc_ready;
  logic [IDX_W-1:0]  alloc_idx;
  logic              cmp_valid;
  logic [IDX_W-1:0]  cmp_idx;
  logic [DATA_W-1:0] cmp_value;
  logic              cmp_fault;
  logic              rf_we;
  logic [AREG_W-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              flush;
  logic [IDX_W-1:0]  flush_idx;
  logic              empty;

  always #2 clk = ~clk;

  retire_ring #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (.*);

  int checks = 0;
  int errors = 0;

  // reference state of the ring
  logic [AREG_W-1:0] m_dest [DEPTH];
  logic [ADDR_W-1:0] m_addr [DEPTH];
  logic [DATA_W-1:0] m_val  [DEPTH];
  bit                m_wen  [DEPTH];
  bit                m_st   [DEPTH];
  bit                m_exc  [DEPTH];
  bit                m_done [DEPTH];
  int                m_head = 0;
  int                m_cnt  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit occupied(input int i);
    return ((i - m_head + DEPTH) % DEPTH) < m_cnt;
  endfunction

  // one cycle: check outputs against the model, drive inputs, advance model
  task automatic step(input bit av, input logic [AREG_W-1:0] dst, input bit wen,
                      input bit st, input logic [ADDR_W-1:0] adr,
                      input bit cv, input int cidx,
                      input logic [DATA_W-1:0] cval, input bit cexc);
    int h = m_head;
    int t = (m_head + m_cnt) % DEPTH;
    bit e_rf = 0, e_mem = 0, e_fl = 0, e_rdy, ret;
    ret = (m_cnt > 0) && m_done[h];
    if (ret) begin
      if (m_exc[h]) e_fl = 1;
      else if (m_st[h]) e_mem = 1;
      else if (m_wen[h]) e_rf = 1;
    end
    e_rdy = (m_cnt < DEPTH) && !e_fl;
    chk(rf_we == e_rf, "R6", "rf_we", rf_we, e_rf);
    if (e_rf) begin
      chk(rf_waddr == m_dest[h], "R6", "rf_waddr", rf_waddr, m_dest[h]);
      chk(rf_wdata == m_val[h], "R6", "rf_wdata", rf_wdata, m_val[h]);
    end
    chk(mem_we == e_mem, "R7", "mem_we", mem_we, e_mem);
    if (e_mem) begin
      chk(mem_addr == m_addr[h], "R7", "mem_addr", mem_addr, m_addr[h]);
      chk(mem_wdata == m_val[h], "R7", "mem_wdata", mem_wdata, m_val[h]);
    end
    chk(flush == e_fl, "R8", "flush", flush, e_fl);
    if (e_fl) chk(flush_idx == IDX_W'(h), "R8", "flush_idx", flush_idx, h);
    if (m_cnt > 0 && !m_done[h])
      chk({rf_we, mem_we, flush} == 3'b000, "R5", "retire while head busy",
          {rf_we, mem_we, flush}, 0);
    chk(empty == (m_cnt == 0), "R2", "empty", empty, m_cnt == 0);
    chk(alloc_ready == e_rdy, "R3", "alloc_ready", alloc_ready, e_rdy);
    chk(alloc_idx == IDX_W'(t), "R2", "alloc_idx", alloc_idx, t);

    alloc_valid  = av;
    alloc_dest   = dst;
    alloc_wr_reg = wen;
    alloc_store  = st;
    alloc_addr   = adr;
    cmp_valid    = cv;
    cmp_idx      = IDX_W'(cidx);
    cmp_value    = cval;
    cmp_fault    = cexc;

    if (cv && !e_fl && occupied(cidx)) begin
      m_val[cidx] = cval; m_exc[cidx] = cexc; m_done[cidx] = 1;
    end
    if (e_fl) m_cnt = 0;
    else if (ret) begin m_head = (m_head + 1) % DEPTH; m_cnt--; end
    if (av && e_rdy) begin
      m_dest[t] = dst; m_wen[t] = wen; m_st[t] = st; m_addr[t] = adr;
      m_done[t] = 0; m_exc[t] = 0; m_cnt++;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, '0, 0, 0, '0, 0, 0, '0, 0);
  endtask

  task automatic alloc(input logic [AREG_W-1:0] dst, input bit wen, input bit st,
                       input logic [ADDR_W-1:0] adr);
    step(1, dst, wen, st, adr, 0, 0, '0, 0);
  endtask

  task automatic complete(input int idx, input logic [DATA_W-1:0] v, input bit e);
    step(0, '0, 0, 0, '0, 1, idx, v, e);
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int slot;
    void'($urandom(32'd77));
    rst_n = 1'b0;
    alloc_valid = 0; alloc_dest = '0; alloc_wr_reg = 0; alloc_store = 0;
    alloc_addr = '0; cmp_valid = 0; cmp_idx = '0; cmp_value = '0; cmp_fault = 0;
    for (int i = 0; i < DEPTH; i++) begin m_done[i] = 0; m_exc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(empty == 1, "R1", "empty", empty, 1);
    chk(alloc_ready == 1, "R1", "alloc_ready", alloc_ready, 1);
    chk(alloc_idx == 0, "R1", "alloc_idx", alloc_idx, 0);
    chk({rf_we, mem_we, flush} == 0, "R1", "retire outputs", {rf_we, mem_we, flush}, 0);

    // R3 fill to depth, then an extra request must be ignored
    for (int i = 0; i < DEPTH; i++) alloc(AREG_W'(i + 1), 1, 0, '0);
    chk(alloc_ready == 0, "R3", "ready when full", alloc_ready, 0);
    alloc(5'd30, 1, 0, '0);
    chk(alloc_idx == 0, "R3", "idx after refused alloc", alloc_idx, 0);
    chk(empty == 0, "R3", "empty when full", empty, 0);

    // R5 younger finishes first, head holds it back
    complete(2, 32'hA2, 0);
    chk(rf_we == 0, "R5", "young slot retired early", rf_we, 0);
    complete(0, 32'hA0, 0);
    chk(rf_we == 1 && rf_waddr == 1 && rf_wdata == 32'hA0, "R6", "head commit",
        rf_wdata, 32'hA0);
    // R10 retire and allocate in one cycle
    complete(1, 32'hA1, 0);
    alloc(5'd9, 1, 0, '0);
    chk(alloc_idx == IDX_W'((m_head + m_cnt) % DEPTH), "R10", "idx after retire+alloc",
        alloc_idx, (m_head + m_cnt) % DEPTH);

    // drain
    while (m_cnt > 0) begin
      slot = m_head;
      if (!m_done[slot]) complete(slot, $urandom, 0);
      else idle();
    end
    idle();

    // R4 completion to a free slot is ignored
    slot = m_head;
    complete(slot, 32'hDEAD, 0);
    alloc(5'd7, 1, 0, '0);
    idle();
    chk(rf_we == 0, "R4", "stale completion retired", rf_we, 0);
    complete(slot, 32'h1234, 0);
    chk(rf_we == 1 && rf_wdata == 32'h1234, "R4", "value after real completion",
        rf_wdata, 32'h1234);
    idle();

    // R9 no-write entry retires silently
    slot = m_head;
    alloc(5'd3, 0, 0, '0);
    complete(slot, 32'h55, 0);
    chk({rf_we, mem_we, flush} == 0 && empty == 0, "R9", "silent retire",
        {rf_we, mem_we, flush}, 0);
    idle();
    chk(empty == 1, "R9", "slot freed", empty, 1);

    // R7 store held until commit
    slot = m_head;
    alloc('0, 0, 1, 32'hC0DE_0040);
    idle(); idle();
    chk(mem_we == 0, "R7", "store before completion", mem_we, 0);
    complete(slot, 32'hBEEF, 0);
    chk(mem_we == 1 && mem_addr == 32'hC0DE_0040 && mem_wdata == 32'hBEEF, "R7",
        "store release", mem_addr, 32'hC0DE_0040);
    idle();

    // R8 fault at head with finished younger work behind it
    slot = m_head;
    alloc(5'd4, 1, 0, '0);
    alloc('0, 0, 1, 32'h80);
    alloc(5'd6, 1, 0, '0);
    complete((slot + 1) % DEPTH, 32'h11, 0);
    complete((slot + 2) % DEPTH, 32'h22, 0);
    complete(slot, 32'h33, 1);
    chk(flush == 1 && flush_idx == IDX_W'(slot) && rf_we == 0 && mem_we == 0 &&
        alloc_ready == 0, "R8", "flush cycle", flush_idx, slot);
    idle();
    chk(empty == 1 && mem_we == 0, "R8", "empty after flush", empty, 1);

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      bit cv = 0, ce = 0;
      int ci = 0;
      if (m_cnt > 0 && ($urandom % 10) < 7) begin
        int off = $urandom % m_cnt;
        ci = (m_head + off) % DEPTH;
        if (!m_done[ci]) begin cv = 1; ce = ($urandom % 50) == 0; end
      end else if (m_cnt < DEPTH && ($urandom % 20) == 0) begin
        cv = 1; ci = (m_head + m_cnt) % DEPTH;
      end
      step(($urandom % 10) < 6, AREG_W'($urandom), ($urandom % 4) != 0,
           ($urandom % 4) == 0, $urandom, cv, ci, $urandom, ce);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule